// File: doc/BRIEF.md
# Staged Escalation Watchdog

This block is a watchdog controller that is clocked by expiry events from its own programmable periodic timer rather than by a single long countdown. Software programs the timer with a period in microsecond ticks, selects which escalation outputs are allowed, and then issues a start command. Every timer expiry moves the watchdog one stage further. The first expiry raises a pending flag and a normal interrupt. The second raises a fast interrupt. The fourth requests a system reset. The timer period is therefore set to one quarter of the intended timeout.

Software keeps the system alive by writing a restart command before escalation gets far. A restart clears the stage count and the pending flag, and it reloads the timer so that a full period separates the restart from the next expiry. Stopping the watchdog is protected: a disable command is accepted only when a magic key was written to the unlock register since the previous command write. Any command write uses up the key. After a timeout the block records a 3-bit reset-reason code that software can read back.

Registers are reached through a simple valid/ready port. The port is always ready. A read returns its data one cycle after the request.

Top module: `wdog_esc`

## Requirements
- R1: The timer reload register (address 0x10) holds enable at bit 31, auto-reload at bit 30 and the period at bits 28:0. While the timer is enabled and periodic, it expires every period × TICK_DIV clock cycles, counted from the latest reload-register write or restart. Writing zero stops all expiries.
- R2: When the auto-reload bit is clear, the timer expires once and then clears its own enable bit. Reading address 0x10 afterwards returns only the period.
- R3: Every expiry sets a timer flag, read at bit 30 of address 0x14. Writing a 1 to that bit clears the flag; writing 0 leaves it unchanged.
- R4: The config register (address 0x00) keeps a source index at bits 3:0, count-enable at bit 4, interrupt enable at bit 12, fast-interrupt enable at bit 13, system-reset enable at bit 14 and power-reset enable at bit 15. All other bits read as 0.
- R5: The first counted expiry after a start sets the pending bit (bit 1 of address 0x04). In the cycle after the expiry it pulses irq_o for one cycle, if the interrupt enable is set.
- R6: The second counted expiry pulses fast_irq_o if that output is enabled. The third expiry pulses nothing.
- R7: The fourth counted expiry pulses sys_rst_req_o and pwr_rst_req_o, each according to its enable, and sets the reset-reason code to 1. Counting then stops until the next start.
- R8: Writing a command (address 0x08) with bit 0 set restarts the watchdog. It clears the stage count and the pending bit and reloads the timer, so repeated restarts within one period prevent any fast interrupt or reset.
- R9: A command with bit 1 set stops the watchdog and clears the pending bit, but only if 0x0000C45A was written to address 0x0C after the previous command write. Otherwise it is ignored. Any command write disarms the key. Bit 0 of address 0x0C reads whether the key is armed.
- R10: The reset-reason code (address 0x18, bits 2:0) is 0 (power-on) after reset and only ever takes a legal value from 0 to 4.
- R11: Expiries do not advance the stages while count-enable is clear or before the first start command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Request accepted (always 1) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 5 | Byte address of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Stage-1 interrupt pulse |
| fast_irq_o | output | 1 | Stage-2 fast interrupt pulse |
| sys_rst_req_o | output | 1 | Direct system reset request pulse |
| pwr_rst_req_o | output | 1 | Power-controller reset request pulse |

## Verification
The assertions check on every cycle the local rules of the block:
- a reset pulse only ever follows an expiry,
- an interrupt pulse always comes with the pending bit,
- a restart always clears that bit,
- a command write always disarms the key,
- an unkeyed command never stops a running watchdog,
- the reason code stays legal.

Only the bench scenarios can show the timing across the whole escalation: the exact cycle of each pulse for a range of periods and all sixteen enable combinations, the effect of repeated restarts, and the consumption of the key by an intervening restart. They also cover the one-shot timer and the behaviour after a stop.

// File: rtl/wdog_esc_pkg.sv
package wdog_esc_pkg;

  localparam int unsigned ADDR_W   = 5;
  localparam int unsigned PERIOD_W = 29;

  localparam logic [ADDR_W-1:0] A_CFG  = 5'h00;
  localparam logic [ADDR_W-1:0] A_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] A_CMD  = 5'h08;
  localparam logic [ADDR_W-1:0] A_KEY  = 5'h0C;
  localparam logic [ADDR_W-1:0] A_TRLD = 5'h10;
  localparam logic [ADDR_W-1:0] A_TFLG = 5'h14;
  localparam logic [ADDR_W-1:0] A_RSN  = 5'h18;

  localparam logic [31:0] UNLOCK_KEY = 32'h0000_C45A;
  localparam int unsigned TRLD_EN_BIT  = 31;
  localparam int unsigned TRLD_PER_BIT = 30;
  localparam int unsigned TFLG_BIT     = 30;
  localparam logic [31:0] TRLD_MASK    = 32'hDFFF_FFFF;

  localparam logic [2:0] RSN_POWER_ON = 3'd0;
  localparam logic [2:0] RSN_WDOG     = 3'd1;
  localparam logic [2:0] RSN_MAX      = 3'd4;

  typedef struct packed {
    logic       pwr_rst_en;
    logic       sys_rst_en;
    logic       fast_en;
    logic       irq_en;
    logic       count_en;
    logic [3:0] src;
  } cfg_t;

  function automatic cfg_t word_to_cfg(input logic [31:0] w);
    cfg_t c;
    c.src        = w[3:0];
    c.count_en   = w[4];
    c.irq_en     = w[12];
    c.fast_en    = w[13];
    c.sys_rst_en = w[14];
    c.pwr_rst_en = w[15];
    return c;
  endfunction

  function automatic logic [31:0] cfg_to_word(input cfg_t c);
    logic [31:0] w;
    w      = '0;
    w[3:0] = c.src;
    w[4]   = c.count_en;
    w[12]  = c.irq_en;
    w[13]  = c.fast_en;
    w[14]  = c.sys_rst_en;
    w[15]  = c.pwr_rst_en;
    return w;
  endfunction

endpackage

// File: rtl/wdog_esc_timer.sv
module wdog_esc_timer
  import wdog_esc_pkg::*;
#(
  parameter int unsigned TICK_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        restart_i,
  output logic [31:0] reload_o,
  output logic        expire_o
);
  localparam int unsigned PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

  logic [31:0]         rld_q;
  logic [PERIOD_W-1:0] cnt_q;
  logic [PRE_W-1:0]    pre_q;
  logic                exp_q;

  logic                run;
  logic                tick;
  logic [PERIOD_W-1:0] period;

  assign run    = rld_q[TRLD_EN_BIT];
  assign period = rld_q[PERIOD_W-1:0];
  assign tick   = run && (pre_q == PRE_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rld_q <= '0;
      cnt_q <= '0;
      pre_q <= '0;
      exp_q <= 1'b0;
    end else begin
      exp_q <= 1'b0;
      if (wr_i) begin
        rld_q <= wdata_i & TRLD_MASK;
        cnt_q <= wdata_i[PERIOD_W-1:0];
        pre_q <= '0;
      end else if (restart_i) begin
        cnt_q <= period;
        pre_q <= '0;
      end else if (run) begin
        if (tick) begin
          pre_q <= '0;
          if (cnt_q <= PERIOD_W'(1)) begin
            exp_q <= 1'b1;
            cnt_q <= period;
            if (!rld_q[TRLD_PER_BIT]) rld_q[TRLD_EN_BIT] <= 1'b0;
          end else begin
            cnt_q <= cnt_q - PERIOD_W'(1);
          end
        end else begin
          pre_q <= pre_q + PRE_W'(1);
        end
      end else begin
        pre_q <= '0;
      end
    end
  end

  assign reload_o = rld_q;
  assign expire_o = exp_q;

  p_expire_needs_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> $past(rld_q[TRLD_EN_BIT]));

  p_oneshot_stops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !$past(rld_q[TRLD_PER_BIT])) |-> !rld_q[TRLD_EN_BIT]);

endmodule

// File: rtl/wdog_esc_stage.sv
module wdog_esc_stage
  import wdog_esc_pkg::*;
#(
  parameter int unsigned EXP_TO_RESET = 4,
  parameter int unsigned FAST_AT      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  cfg_t       cfg_i,
  output logic       running_o,
  output logic       status_o,
  output logic       irq_o,
  output logic       fiq_o,
  output logic       sys_rst_o,
  output logic       pwr_rst_o,
  output logic [2:0] reason_o
);
  localparam int unsigned SW = $clog2(EXP_TO_RESET + 1);
  localparam logic [SW-1:0] ST_FIRST = SW'(1);
  localparam logic [SW-1:0] ST_FAST  = SW'(FAST_AT);
  localparam logic [SW-1:0] ST_RESET = SW'(EXP_TO_RESET);

  function automatic logic [SW-1:0] stage_step(input logic [SW-1:0] s);
    return (s >= ST_RESET) ? ST_RESET : s + SW'(1);
  endfunction

  logic [SW-1:0] stage_q;
  logic          running_q, status_q;
  logic          irq_q, fiq_q, srst_q, prst_q;
  logic [2:0]    rsn_q;
  logic          advance;
  logic [SW-1:0] stage_nxt;

  assign advance   = expire_i && running_q && cfg_i.count_en;
  assign stage_nxt = stage_step(stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q   <= '0;
      running_q <= 1'b0;
      status_q  <= 1'b0;
      irq_q     <= 1'b0;
      fiq_q     <= 1'b0;
      srst_q    <= 1'b0;
      prst_q    <= 1'b0;
      rsn_q     <= RSN_POWER_ON;
    end else begin
      irq_q  <= 1'b0;
      fiq_q  <= 1'b0;
      srst_q <= 1'b0;
      prst_q <= 1'b0;
      if (stop_i) begin
        running_q <= 1'b0;
        stage_q   <= '0;
        status_q  <= 1'b0;
      end else if (start_i) begin
        running_q <= 1'b1;
        stage_q   <= '0;
        status_q  <= 1'b0;
      end else if (advance) begin
        stage_q <= stage_nxt;
        if (stage_nxt == ST_FIRST) begin
          status_q <= 1'b1;
          irq_q    <= cfg_i.irq_en;
        end
        if (stage_nxt == ST_FAST) fiq_q <= cfg_i.fast_en;
        if (stage_nxt == ST_RESET) begin
          srst_q    <= cfg_i.sys_rst_en;
          prst_q    <= cfg_i.pwr_rst_en;
          rsn_q     <= RSN_WDOG;
          running_q <= 1'b0;
        end
      end
    end
  end

  assign running_o = running_q;
  assign status_o  = status_q;
  assign irq_o     = irq_q;
  assign fiq_o     = fiq_q;
  assign sys_rst_o = srst_q;
  assign pwr_rst_o = prst_q;
  assign reason_o  = rsn_q;

  p_irq_with_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> status_o);

  p_fast_after_expiry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> ($past(expire_i) && status_o));

  p_rst_after_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst_o || pwr_rst_o) |-> ($past(expire_i) && !running_o && reason_o == RSN_WDOG));

  p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !stop_i) |=> (!status_o && running_o));

  p_reason_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
    reason_o <= RSN_MAX);

  p_idle_no_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!running_o && !start_i) |=> !(irq_o || fiq_o || sys_rst_o || pwr_rst_o));

endmodule

// File: rtl/wdog_esc.sv
module wdog_esc
  import wdog_esc_pkg::*;
#(
  parameter int unsigned TICK_DIV     = 4,
  parameter int unsigned EXP_TO_RESET = 4,
  parameter int unsigned FAST_AT      = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid_i,
  output logic        req_ready_o,
  input  logic        req_write_i,
  input  logic [4:0]  req_addr_i,
  input  logic [31:0] req_wdata_i,
  output logic        rsp_valid_o,
  output logic [31:0] rsp_rdata_o,
  output logic        irq_o,
  output logic        fast_irq_o,
  output logic        sys_rst_req_o,
  output logic        pwr_rst_req_o
);
  logic        wr, rd;
  logic        wr_cfg, wr_cmd, wr_key, wr_trld, wr_tflg;
  logic        start_cmd, stop_cmd;
  logic        key_armed_q, tflag_q;
  cfg_t        cfg_q;
  logic [31:0] reload;
  logic        expire, running, status;
  logic [2:0]  reason;
  logic [31:0] rd_data;
  logic        rsp_valid_q;
  logic [31:0] rsp_data_q;

  assign req_ready_o = 1'b1;
  assign wr      = req_valid_i && req_write_i;
  assign rd      = req_valid_i && !req_write_i;
  assign wr_cfg  = wr && (req_addr_i == A_CFG);
  assign wr_cmd  = wr && (req_addr_i == A_CMD);
  assign wr_key  = wr && (req_addr_i == A_KEY);
  assign wr_trld = wr && (req_addr_i == A_TRLD);
  assign wr_tflg = wr && (req_addr_i == A_TFLG);

  assign stop_cmd  = wr_cmd && req_wdata_i[1] && key_armed_q;
  assign start_cmd = wr_cmd && req_wdata_i[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '0;
      key_armed_q <= 1'b0;
      tflag_q     <= 1'b0;
    end else begin
      if (wr_cfg) cfg_q <= word_to_cfg(req_wdata_i);
      if (wr_cmd)      key_armed_q <= 1'b0;
      else if (wr_key) key_armed_q <= (req_wdata_i == UNLOCK_KEY);
      if (expire)                                tflag_q <= 1'b1;
      else if (wr_tflg && req_wdata_i[TFLG_BIT]) tflag_q <= 1'b0;
    end
  end

  wdog_esc_timer #(.TICK_DIV(TICK_DIV)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (wr_trld),
    .wdata_i   (req_wdata_i),
    .restart_i (start_cmd && !stop_cmd),
    .reload_o  (reload),
    .expire_o  (expire)
  );

  wdog_esc_stage #(.EXP_TO_RESET(EXP_TO_RESET), .FAST_AT(FAST_AT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .expire_i  (expire),
    .start_i   (start_cmd),
    .stop_i    (stop_cmd),
    .cfg_i     (cfg_q),
    .running_o (running),
    .status_o  (status),
    .irq_o     (irq_o),
    .fiq_o     (fast_irq_o),
    .sys_rst_o (sys_rst_req_o),
    .pwr_rst_o (pwr_rst_req_o),
    .reason_o  (reason)
  );

  always_comb begin
    rd_data = '0;
    case (req_addr_i)
      A_CFG:   rd_data = cfg_to_word(cfg_q);
      A_STAT:  rd_data[1] = status;
      A_KEY:   rd_data[0] = key_armed_q;
      A_TRLD:  rd_data = reload;
      A_TFLG:  rd_data[TFLG_BIT] = tflag_q;
      A_RSN:   rd_data[2:0] = reason;
      default: rd_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= rd;
      if (rd) rsp_data_q <= rd_data;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_rdata_o = rsp_data_q;

  p_key_consumed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> !key_armed_q);

  p_unkeyed_stop_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cmd && !key_armed_q && running && !expire) |=> running);

  p_tflag_on_expiry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> tflag_q);

endmodule

// File: tb/test_wdog_esc.sv
module test_wdog_esc;
  localparam int CLK_PERIOD = 10;
  localparam int TDIV       = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [4:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq, fiq, srst, prst;

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  int n_irq = 0, n_fiq = 0, n_srst = 0, n_prst = 0;
  int t_irq = 0, t_fiq = 0, t_srst = 0, t_prst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_esc #(.TICK_DIV(TDIV)) i_wdog_esc (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq), .fast_irq_o(fiq), .sys_rst_req_o(srst), .pwr_rst_req_o(prst)
  );

  always @(negedge clk) begin
    if (irq)  begin n_irq++;  t_irq  = cyc; end
    if (fiq)  begin n_fiq++;  t_fiq  = cyc; end
    if (srst) begin n_srst++; t_srst = cyc; end
    if (prst) begin n_prst++; t_prst = cyc; end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_rdata : 32'hDEAD_BEEF;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // expected observation cycle of the pulse caused by expiry k after a start at W
  function automatic int pulse_at(input int w, input int k, input int p);
    return w + k * p * TDIV + 1;
  endfunction

  task automatic finish_bench();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  task automatic run_esc(input int p, input int en);
    logic [31:0] d;
    int w, b_irq, b_fiq, b_srst, b_prst;
    wr(5'h00, (32'(en) << 12) | 32'h13);
    wr(5'h10, 32'hC000_0000 | 32'(p));
    wr(5'h08, 32'h1);
    w = cyc;
    b_irq = n_irq; b_fiq = n_fiq; b_srst = n_srst; b_prst = n_prst;
    wait_until(pulse_at(w, 4, p) + 2);
    chk("R5 irq count", 32'(n_irq - b_irq), 32'(en & 1));
    if (en[0]) chk("R5 irq cycle", 32'(t_irq), 32'(pulse_at(w, 1, p)));
    chk("R6 fast count", 32'(n_fiq - b_fiq), 32'((en >> 1) & 1));
    if (en[1]) chk("R6 fast cycle", 32'(t_fiq), 32'(pulse_at(w, 2, p)));
    chk("R7 sys rst count", 32'(n_srst - b_srst), 32'((en >> 2) & 1));
    if (en[2]) chk("R7 sys rst cycle", 32'(t_srst), 32'(pulse_at(w, 4, p)));
    chk("R7 pwr rst count", 32'(n_prst - b_prst), 32'((en >> 3) & 1));
    if (en[3]) chk("R7 pwr rst cycle", 32'(t_prst), 32'(pulse_at(w, 4, p)));
    rd(5'h18, d); chk("R7 reason code", d, 32'd1);
    rd(5'h04, d); chk("R5 status pending", d, 32'h2);
    if (en == 15) begin
      repeat (3 * p * TDIV) @(negedge clk);
      chk("R7 counting stopped", 32'(n_irq + n_fiq + n_srst + n_prst - b_irq - b_fiq - b_srst - b_prst), 32'd4);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_bench();
  end

  initial begin
    logic [31:0] d;
    int w, b;
    do_reset();

    // reset state
    chk("R10 ready tied high", 32'(req_ready), 32'd1);
    chk("R10 outputs idle", 32'({irq, fiq, srst, prst}), 32'd0);
    rd(5'h18, d); chk("R10 reason after reset", d, 32'd0);
    rd(5'h00, d); chk("R4 cfg after reset", d, 32'd0);
    rd(5'h04, d); chk("R5 status after reset", d, 32'd0);
    rd(5'h10, d); chk("R1 reload after reset", d, 32'd0);

    // R4 config field mask
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, d); chk("R4 cfg mask", d, 32'h0000_F01F);
    wr(5'h00, 32'h0000_5A35);
    rd(5'h00, d); chk("R4 cfg fields", d, 32'h0000_5015);

    // R11 not started: timer runs, no stage activity
    wr(5'h00, 32'h0000_F010);
    wr(5'h10, 32'hC000_0002);
    b = n_irq + n_fiq + n_srst + n_prst;
    repeat (12 * TDIV) @(negedge clk);
    chk("R11 no pulses before start", 32'(n_irq + n_fiq + n_srst + n_prst - b), 32'd0);
    rd(5'h04, d); chk("R11 no status before start", d, 32'd0);

    // R11 count enable clear
    wr(5'h00, 32'h0000_F000);
    wr(5'h08, 32'h1);
    repeat (12 * TDIV) @(negedge clk);
    chk("R11 no pulses with count disabled", 32'(n_irq + n_fiq + n_srst + n_prst - b), 32'd0);
    rd(5'h04, d); chk("R11 no status with count disabled", d, 32'd0);

    // R2 / R3 one-shot timer and flag
    do_reset();
    wr(5'h10, 32'h8000_0003);
    w = cyc;
    wait_until(w + 3 * TDIV + 2);
    rd(5'h10, d); chk("R2 enable cleared after one shot", d, 32'd3);
    rd(5'h14, d); chk("R3 flag set on expiry", d, 32'h4000_0000);
    wr(5'h14, 32'h0);
    rd(5'h14, d); chk("R3 writing zero keeps flag", d, 32'h4000_0000);
    wr(5'h14, 32'h4000_0000);
    rd(5'h14, d); chk("R3 write one clears flag", d, 32'd0);
    repeat (10 * TDIV) @(negedge clk);
    rd(5'h14, d); chk("R2 no further expiry", d, 32'd0);

    // R1 zero stops the timer
    wr(5'h00, 32'h0000_1010);
    wr(5'h10, 32'hC000_0003);
    wr(5'h08, 32'h1);
    wr(5'h10, 32'h0);
    b = n_irq;
    repeat (12 * TDIV) @(negedge clk);
    chk("R1 zero reload stops expiries", 32'(n_irq - b), 32'd0);
    rd(5'h14, d); chk("R1 no flag after stop", d, 32'd0);

    // R1 R5 R6 R7 sweep over periods and all enable combinations
    for (int p = 1; p <= 3; p++)
      for (int en = 0; en < 16; en++)
        run_esc(p, en);

    // R8 repeated restarts hold off escalation
    wr(5'h00, 32'h0000_F010);
    wr(5'h10, 32'hC000_0003);
    b = n_fiq + n_srst + n_prst;
    for (int i = 0; i < 6; i++) begin
      wr(5'h08, 32'h1);
      w = cyc;
      if (i == 0) begin
        rd(5'h04, d); chk("R8 restart clears status", d, 32'd0);
      end
      wait_until(w + 3 * TDIV + 2);
      chk("R8 one irq per restart period", 32'(t_irq), 32'(pulse_at(w, 1, 3)));
    end
    chk("R8 no fast or reset under restarts", 32'(n_fiq + n_srst + n_prst - b), 32'd0);

    // R9 unlock protection
    wr(5'h00, 32'h0000_1010);
    wr(5'h10, 32'hC000_0005);
    wr(5'h08, 32'h1);
    w = cyc;
    b = n_irq;
    wr(5'h08, 32'h2);
    wait_until(pulse_at(w, 1, 5) + 1);
    chk("R9 unkeyed disable ignored", 32'(n_irq - b), 32'd1);
    rd(5'h0C, d); chk("R9 key not armed", d, 32'd0);
    wr(5'h0C, 32'h0000_1234);
    rd(5'h0C, d); chk("R9 wrong key not armed", d, 32'd0);
    wr(5'h0C, 32'h0000_C45A);
    rd(5'h0C, d); chk("R9 key armed", d, 32'd1);
    wr(5'h08, 32'h1);
    w = cyc;
    rd(5'h0C, d); chk("R9 key consumed by restart", d, 32'd0);
    b = n_irq;
    wr(5'h08, 32'h2);
    wait_until(pulse_at(w, 1, 5) + 1);
    chk("R9 disable after consumed key ignored", 32'(n_irq - b), 32'd1);
    wr(5'h0C, 32'h0000_C45A);
    wr(5'h08, 32'h2);
    rd(5'h04, d); chk("R9 keyed disable clears status", d, 32'd0);
    b = n_irq + n_fiq + n_srst + n_prst;
    repeat (25 * TDIV) @(negedge clk);
    chk("R9 keyed disable stops watchdog", 32'(n_irq + n_fiq + n_srst + n_prst - b), 32'd0);
    rd(5'h18, d); chk("R10 reason stays legal", d, 32'd1);

    finish_bench();
  end
endmodule